// File: doc/BRIEF.md
# Look-up Table Logic Element with Register Bypass

This block is one configurable logic element of the kind an FPGA replicates inside each logic block. A K-input look-up table holds 2^K stored bits that form the truth table of any Boolean function of its inputs. The input pattern on `sel_in`, read as an unsigned number, picks one stored bit as the function value.

The function value can go straight to the output, or it can be captured in a D flip-flop and presented one clock later. A single stored select bit makes that choice. The truth table and the select bit are loaded serially through a configuration shift chain that moves one bit per clock while `cfg_en` is high. The surrounding routing fabric drives this chain.

A synchronous reset clears only the flip-flop. The loaded function survives reset.

Top module: `lut_cell`

## Requirements
- R1: With the bypass bit set to 1, `dout` equals the stored truth-table bit at address `sel_in`, taking `sel_in` as an unsigned number from 0 to 2^K-1.
- R2: Any 2^K-bit pattern can be loaded, and each pattern gives the matching function. For example, the pattern that is 1 wherever `sel_in[0]` equals `sel_in[1]` gives an equality detector on those two inputs.
- R3: While `cfg_en` is 1, the chain takes one bit from `cfg_in` on each rising edge. A full load is 2^K+1 bits: the truth-table bits for addresses 2^K-1 down to 0, in that order, followed by the bypass bit.
- R4: With the bypass bit set, a change on `sel_in` shows on `dout` in the same cycle, without waiting for a clock edge.
- R5: With the bypass bit at 0, `dout` is the look-up value that was present at the previous rising edge on which `rst` was 0 and `cfg_en` was 0.
- R6: While `cfg_en` is 1, the flip-flop keeps its value.
- R7: With `rst` at 1 at a rising edge, the flip-flop is cleared to 0 and the loaded configuration is kept.
- R8: While `cfg_en` is 0, the configuration does not change, whatever `cfg_in` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset of the output flip-flop, active high |
| cfg_en | input | 1 | Enables shifting of the configuration chain |
| cfg_in | input | 1 | Serial configuration data |
| sel_in | input | K | Logic inputs that address the truth table |
| dout | output | 1 | Logic element output |

## Verification
The assertions check on every cycle four things: the flip-flop captures the look-up value, it holds while the chain is shifting, it clears on reset, and the configuration stays fixed while `cfg_en` is low. The bench's scenarios are needed for the rest. Only they show that the serial bit order places each truth-table bit at the right address and the bypass bit last. They also show that particular loaded functions, such as the equality detector, come out correct, and that the function still works after a reset.

// File: rtl/lut_cell.sv
module lut_cell #(
  parameter int K = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_en,
  input  logic         cfg_in,
  input  logic [K-1:0] sel_in,
  output logic         dout
);
  localparam int ENTRIES = 1 << K;
  localparam int W       = ENTRIES + 1;

  logic [W-1:0]       cfg_q;
  logic [ENTRIES-1:0] table_bits;
  logic               bypass;
  logic               lut_val;
  logic               ff_q;

  always_ff @(posedge clk)
    if (cfg_en) cfg_q <= {cfg_q[W-2:0], cfg_in};

  assign table_bits = cfg_q[W-1:1];
  assign bypass     = cfg_q[0];
  assign lut_val    = table_bits[sel_in];

  always_ff @(posedge clk)
    if (rst)          ff_q <= 1'b0;
    else if (!cfg_en) ff_q <= lut_val;

  assign dout = bypass ? lut_val : ff_q;
endmodule

module lut_cell_chk #(
  parameter int W = 17
) (
  input logic         clk,
  input logic         rst,
  input logic         cfg_en,
  input logic [W-1:0] cfg_q,
  input logic         ff_q,
  input logic         lut_val
);
  // R5
  ff_capture_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> ff_q == $past(lut_val));

  // R6
  ff_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> $stable(ff_q));

  // R7
  ff_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> ff_q == 1'b0);

  // R8
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> $stable(cfg_q));
endmodule

bind lut_cell lut_cell_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .cfg_en(cfg_en),
  .cfg_q(cfg_q), .ff_q(ff_q), .lut_val(lut_val)
);

// File: tb/tb_lut_cell.sv
`timescale 1ns/1ps
module tb_lut_cell;
  localparam int K = 4;
  localparam int ENTRIES = 1 << K;
  localparam int W = ENTRIES + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_en = 1'b1;
  logic cfg_in = 1'b0;
  logic [K-1:0] sel_in = '0;
  logic dout;

  int checks = 0;
  int failures = 0;

  bit hist[$];
  bit m_q = 1'b0;

  always #2.5 clk = ~clk;

  lut_cell #(.K(K)) dut (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_in(cfg_in),
    .sel_in(sel_in), .dout(dout)
  );

  function automatic bit ready();
    return hist.size() == W;
  endfunction

  function automatic bit m_lut(int a);
    return hist[W-2-a];
  endfunction

  function automatic bit m_byp();
    return hist[W-1];
  endfunction

  task automatic check(logic act, logic exp, string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: dout=%b expected=%b (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit r, bit e, bit ci, logic [K-1:0] a, string tag);
    bit lv;
    string t;
    @(negedge clk);
    rst = r; cfg_en = e; cfg_in = ci; sel_in = a;
    #1;
    if (ready()) begin
      lv = m_lut(int'(a));
      if (tag != "") t = tag;
      else if (e && !m_byp()) t = "R6";
      else t = m_byp() ? "R4" : "R5";
      check(dout, m_byp() ? lv : m_q, t);
    end
    @(posedge clk);
    if (r) m_q = 1'b0;
    else if (!e && ready()) m_q = m_lut(int'(a));
    if (e) begin
      hist.push_back(ci);
      if (hist.size() > W) void'(hist.pop_front());
    end
  endtask

  task automatic load(logic [ENTRIES-1:0] pat, bit byp);
    for (int i = ENTRIES - 1; i >= 0; i--)
      step(1'b0, 1'b1, pat[i], K'($urandom), "R3");
    step(1'b0, 1'b1, byp, K'($urandom), "R3");
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [ENTRIES-1:0] eq_pat;
    for (int a = 0; a < ENTRIES; a++) eq_pat[a] = (a[0] == a[1]);

    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, '0, "R7");

    // R3: only address 15 set, bypass on
    load(16'h8000, 1'b1);
    step(1'b0, 1'b0, 1'b1, 4'd15, "R3");
    step(1'b0, 1'b0, 1'b0, 4'd14, "R3");
    step(1'b0, 1'b0, 1'b0, 4'd0,  "R3");

    // R1/R2: equality detector on inputs 0 and 1
    load(eq_pat, 1'b1);
    for (int a = 0; a < ENTRIES; a++) step(1'b0, 1'b0, 1'b0, K'(a), "R1");

    // R2/R4: arbitrary pattern, sweep
    load(16'hB3C6, 1'b1);
    for (int a = ENTRIES - 1; a >= 0; a--) step(1'b0, 1'b0, 1'b0, K'(a), "R2");

    // R5: registered mode
    load(16'h6A91, 1'b0);
    for (int i = 0; i < 40; i++) step(1'b0, 1'b0, 1'b0, K'($urandom), "R5");

    // R6: reload while in registered mode, flop must hold
    load(16'h0FF0, 1'b0);
    for (int i = 0; i < 10; i++) step(1'b0, 1'b0, 1'b0, K'($urandom), "R5");

    // R7: reset clears flop, configuration kept
    step(1'b1, 1'b0, 1'b1, 4'd5, "R7");
    step(1'b0, 1'b0, 1'b0, 4'd5, "R7");
    for (int i = 0; i < 10; i++) step(1'b0, 1'b0, 1'b0, K'($urandom), "R7");

    // R8: cfg_in toggling with cfg_en low
    load(16'h5AA5, 1'b1);
    for (int i = 0; i < 32; i++) step(1'b0, 1'b0, 1'($urandom), K'(i), "R8");

    // R4: back-to-back input changes in bypass
    for (int i = 0; i < 20; i++) step(1'b0, 1'b0, 1'b0, K'($urandom), "R4");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule